// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable model of a byte-wide nonvolatile memory that answers as a slave on a two-wire, I2C-compatible bus. The bus lines are oversampled by the system clock. The block watches for START and STOP conditions, clocks in bytes on SCL rising edges, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero bit. A control byte selects the device through three strap inputs and sets the transfer direction. For writes, two word-address bytes follow the control byte, and then data bytes are collected in a page latch.

When a write transaction ends with a STOP, the latched bytes are copied into the array and a self-timed program cycle starts. While that cycle runs, the block refuses its control byte, so the host can poll until the write has finished. Any write that closes while the write-protect input is high leaves the array untouched. Reads come in three forms:
- a random read, which sets the address with a dummy write and then a repeated START;
- a current-address read, which carries on from the last byte accessed;
- a sequential read, which keeps going for as long as the master acknowledges.

The array depth, the page size and the length of the program cycle are parameters. With the defaults, the array is 512 bytes, a page is 64 bytes and the cycle is 5 ms at 50 MHz. The word address has 14 bits, and only the bits that index the array are used.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the block does not drive SDA (sda_oe_o = 0), and every array byte reads 8'hFF.
- R2: A control byte is acknowledged only when bits 7:4 equal 4'b1010 and bits 3:1 equal strap_i (bit 3 carries strap_i[2]). Bit 0 selects the direction, 1 for read. Any other control byte is not acknowledged.
- R3: After a STOP that ends a write carrying at least one data byte with wp_i low, the control byte is refused for WR_CYCLES clock cycles and is acknowledged again once that time has passed.
- R4: In a write, the first address byte after the control byte is the high part of the word address and the second is the low part. A byte written this way is returned by a later random read of that address.
- R5: Within one write, the address advances only in its low PAGE_W bits. Bytes past the page end wrap to the page start and overwrite the bytes loaded earlier.
- R6: When wp_i is high at the STOP, data bytes are still acknowledged, but no program cycle starts (the next control byte is acknowledged at once) and the array is unchanged.
- R7: A sequential read returns consecutive addresses and rolls over from the top address to address 0.
- R8: A read that starts directly with a read control byte returns the byte that follows the last one accessed.
- R9: Word-address bits at and above MEM_AW are ignored.
- R10: After the master answers a read byte with NACK, the block releases SDA and sends nothing more until the next START.
- R11: A write that carries only an address and no data byte starts no program cycle.
- R12: Apart from START and STOP handling, the block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Device select straps |
| wp_i | input | 1 | Write-protect for the whole array, active high |
| sda_oe_o | output | 1 | When high, pull SDA low |

## Verification
The assertions assume a bus master that changes SDA only while SCL is low, except when it creates a START or a STOP. They also assume that every SCL level is held for several system clocks, so the synchronizer sees each edge, and that wp_i stays steady around a STOP. The bench master drives each quarter bit for six clocks on the falling system-clock edge, so every level lasts at least twice the synchronizer delay. The bench changes wp_i only while the bus is idle. Because the bus is wired-AND, the model combines the bench's drive with sda_oe_o.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK} bus_st_e;
  typedef enum logic [1:0] {K_CTRL, K_AHI, K_ALO, K_DATA} frame_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_eeprom_cond.sv
module i2c_eeprom_cond #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  // stage 0 takes the raw pins; the last stage holds the previous sample
  logic [1:0] pipe_q [SYNC+1];

  for (genvar g = 0; g <= SYNC; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= 2'b11;
      else if (g == 0) pipe_q[g] <= {scl_i, sda_i};
      else pipe_q[g] <= pipe_q[g-1];
    end
  end

  logic scl_p, sda_p;
  assign {scl_o, sda_o} = pipe_q[SYNC-1];
  assign {scl_p, sda_p} = pipe_q[SYNC];

  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_eeprom_store.sv
module i2c_eeprom_store #(
  parameter int MEM_AW    = 9,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 250000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lat_clr_i,
  input  logic                     lat_we_i,
  input  logic [PAGE_W-1:0]        lat_idx_i,
  input  logic [7:0]               lat_data_i,
  input  logic                     prog_i,
  input  logic [MEM_AW-PAGE_W-1:0] page_i,
  input  logic [MEM_AW-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  logic [7:0]      mem_q [DEPTH];
  logic [7:0]      lat_q [PAGE];
  logic [PAGE-1:0] vld_q;
  logic [CW-1:0]   tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < PAGE; i++) lat_q[i] <= 8'h00;
    end else if (lat_clr_i || prog_i) begin
      vld_q <= '0;
    end else if (lat_we_i) begin
      vld_q[lat_idx_i] <= 1'b1;
      lat_q[lat_idx_i] <= lat_data_i;
    end
  end

  // a whole page is committed in one cycle; the timer then models the program time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) mem_q[d] <= 8'hFF;
    end else if (prog_i) begin
      for (int i = 0; i < PAGE; i++)
        if (vld_q[i]) mem_q[{page_i, PAGE_W'(i)}] <= lat_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else if (prog_i) tmr_q <= CW'(WR_CYCLES);
    else if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
  end

  assign busy_o    = (tmr_q != '0);
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int MEM_AW    = 9,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int HI_W = (MEM_AW > 8) ? MEM_AW - 8 : 1;
  localparam int PG_W = MEM_AW - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, prog, lat_clr, lat_we;
  logic [7:0] rd_data;

  bus_st_e           st_q;
  frame_e            kind_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic              rw_q, mack_q, wr_pend_q, sda_oe_q;
  logic [HI_W-1:0]   ahi_q;
  logic [MEM_AW-1:0] addr_q;
  logic [HI_W+7:0]   wa;

  i2c_eeprom_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  logic byte_done, ctrl_hit;
  assign byte_done = (st_q == ST_RX) && scl_fall && (cnt_q == 4'd8);
  assign ctrl_hit  = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i) && !busy;
  assign lat_clr   = byte_done && (kind_q == K_ALO);
  assign lat_we    = byte_done && (kind_q == K_DATA);
  assign prog      = stop_ev && wr_pend_q && !wp_i;
  assign wa        = {ahi_q, sh_q};

  i2c_eeprom_store #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .lat_clr_i(lat_clr), .lat_we_i(lat_we),
    .lat_idx_i(addr_q[PAGE_W-1:0]), .lat_data_i(sh_q),
    .prog_i(prog), .page_i(addr_q[MEM_AW-1:PAGE_W]),
    .rd_addr_i(addr_q), .rd_data_o(rd_data), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_CTRL;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      wr_pend_q <= 1'b0;
      sda_oe_q  <= 1'b0;
      ahi_q     <= '0;
      addr_q    <= '0;
    end else if (start_ev) begin
      st_q      <= ST_RX;
      kind_q    <= K_CTRL;
      cnt_q     <= '0;
      sda_oe_q  <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (stop_ev) begin
      st_q      <= ST_IDLE;
      sda_oe_q  <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_q    <= '0;
            st_q     <= ST_ACK;
            sda_oe_q <= 1'b1;
            unique case (kind_q)
              K_CTRL: begin
                rw_q <= sh_q[0];
                if (!ctrl_hit) begin
                  st_q     <= ST_IDLE;
                  sda_oe_q <= 1'b0;
                end
              end
              K_AHI:  ahi_q  <= sh_q[HI_W-1:0];
              K_ALO:  addr_q <= wa[MEM_AW-1:0];
              K_DATA: begin
                wr_pend_q <= 1'b1;
                addr_q    <= {addr_q[MEM_AW-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              end
              default: ;
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (kind_q == K_CTRL && rw_q) begin
            st_q     <= ST_TX;
            sh_q     <= rd_data;
            sda_oe_q <= ~rd_data[7];
            addr_q   <= addr_q + 1'b1;
          end else begin
            st_q     <= ST_RX;
            sda_oe_q <= 1'b0;
            unique case (kind_q)
              K_CTRL:  kind_q <= K_AHI;
              K_AHI:   kind_q <= K_ALO;
              default: kind_q <= K_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 1'b1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              st_q     <= ST_RACK;
              cnt_q    <= '0;
              sda_oe_q <= 1'b0;
            end else begin
              sh_q     <= {sh_q[6:0], 1'b0};
              sda_oe_q <= ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              st_q     <= ST_TX;
              sh_q     <= rd_data;
              sda_oe_q <= ~rd_data[7];
              addr_q   <= addr_q + 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  logic unused_pg;
  assign unused_pg = ^{PG_W[0]};
endmodule

// File: rtl/i2c_eeprom_chk.sv
module i2c_eeprom_chk
  import i2c_eeprom_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    scl_s,
  input logic    sda_oe_o,
  input logic    busy,
  input logic    wp_i,
  input logic    wr_pend,
  input bus_st_e st,
  input frame_e  kind
);
  // R12
  sda_low_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  // R6
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(!wp_i));

  // R11
  prog_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_pend));

  // R3
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACK && kind == K_CTRL && busy) |-> !sda_oe_o);

  // R10
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
endmodule

bind i2c_eeprom_slave i2c_eeprom_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .busy(busy), .wp_i(wp_i), .wr_pend(wr_pend_q), .st(st_q), .kind(kind_q)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int AW = 7;
  localparam int PW = 3;
  localparam int WRC = 400;
  localparam int Q = 6;
  localparam int AMASK = (1 << AW) - 1;
  localparam int PMASK = (1 << PW) - 1;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, bus_sda;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] ref_mem [1 << AW];

  assign bus_sda = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  i2c_eeprom_slave #(.MEM_AW(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q);
  endtask

  task automatic write_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = (bus_sda == 1'b0); tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); d[i] = bus_sda; tick(Q); scl_m = 0; tick(Q);
    end
    send_bit(!mack);
  endtask

  function automatic logic [7:0] ctrl(logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic addr_phase(logic [7:0] hi, logic [7:0] lo, output logic ok);
    logic a0, a1, a2;
    i2c_start; write_byte(ctrl(1'b0), a0); write_byte(hi, a1); write_byte(lo, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic poll(output int nacks);
    logic a;
    nacks = 0;
    a = 1'b0;
    while (!a && nacks < 50) begin
      i2c_start; write_byte(ctrl(1'b0), a); i2c_stop;
      if (!a) nacks++;
    end
  endtask

  task automatic read_from(logic [7:0] hi, logic [7:0] lo, int n, string tag);
    logic ok, a;
    logic [7:0] d;
    int base;
    base = {hi, lo} & AMASK;
    addr_phase(hi, lo, ok);
    check({tag, " address ack"}, ok, 1);
    i2c_start; write_byte(ctrl(1'b1), a);
    check({tag, " read ctrl ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(d, k != n - 1);
      check(tag, d, ref_mem[(base + k) & AMASK]);
    end
    i2c_stop;
  endtask

  task automatic page_write(logic [7:0] hi, logic [7:0] lo, int n, int seed, string tag);
    logic ok, a;
    logic [7:0] d;
    int base;
    base = {hi, lo} & AMASK;
    addr_phase(hi, lo, ok);
    check({tag, " address ack"}, ok, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'((k * 29 + seed) & 8'hFF);
      write_byte(d, a);
      check({tag, " data ack"}, a, 1);
      if (!wp) ref_mem[(base & ~PMASK) | ((base + k) & PMASK)] = d;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int np;
    for (int i = 0; i <= AMASK; i++) ref_mem[i] = 8'hFF;
    tick(5); rst_n = 1; tick(5);

    // R1: line released after reset
    check("R1 sda release", sda_oe, 0);

    // R2: strap sweep plus a wrong device code
    for (int s = 0; s < 8; s++) begin
      i2c_start; write_byte({4'b1010, 3'(s), 1'b0}, a); i2c_stop;
      check("R2 strap match", a, (s == STRAP) ? 1 : 0);
    end
    i2c_start; write_byte({4'b1011, STRAP, 1'b0}, a); i2c_stop;
    check("R2 wrong code", a, 0);

    // R1: erased array
    read_from(8'h00, 8'h05, 2, "R1 erased read");

    // R11: address-only write leaves the device ready
    i2c_start; write_byte(ctrl(1'b0), a); i2c_stop;
    check("R11 no program after address-only", a, 1);

    // R4 + R3: byte write, busy NACK, then ack polling
    page_write(8'h00, 8'h10, 1, 8'h3C - 0, "R4 byte write");
    i2c_start; write_byte(ctrl(1'b0), a); i2c_stop;
    check("R3 busy nack", a, 0);
    poll(np);
    check("R3 ack resumes", (np < 50) ? 1 : 0, 1);
    read_from(8'h00, 8'h10, 1, "R4 random read");

    // R5: 11 bytes from mid-page wrap onto the page start
    page_write(8'h00, 8'h45, 11, 8'hA0, "R5 wrap write");
    poll(np);
    read_from(8'h00, 8'h40, 8, "R5 page content");

    // R6: protected write acks data, starts nothing, changes nothing
    wp = 1'b1;
    page_write(8'h00, 8'h11, 3, 8'h55, "R6 protected write");
    i2c_start; write_byte(ctrl(1'b0), a); i2c_stop;
    check("R6 no busy", a, 1);
    wp = 1'b0;
    read_from(8'h00, 8'h10, 4, "R6 unchanged");

    // R4/R5/R7: fill every page, then read the whole array
    for (int p = 0; p <= AMASK; p += PMASK + 1) begin
      page_write(8'h00, 8'(p), PMASK + 1, p + 7, "R5 fill");
      poll(np);
    end
    read_from(8'h00, 8'h00, AMASK + 1, "R7 sequential");

    // R7: rollover past top
    read_from(8'h00, 8'(AMASK - 1), 4, "R7 rollover");

    // R8: current address continues at 2
    i2c_start; write_byte(ctrl(1'b1), a);
    check("R8 ctrl ack", a, 1);
    read_byte(d, 1'b0);
    check("R8 current read", d, ref_mem[2]);
    // R10: released after master NACK, before STOP
    tick(Q);
    check("R10 released after nack", bus_sda, 1);
    check("R10 oe low", sda_oe, 0);
    i2c_stop;

    // R9: upper word address bits ignored
    read_from(8'hFF, 8'h90, 2, "R9 alias read");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule